// File: doc/BRIEF.md
# Zero-overhead hardware loop controller

This block lets a simple in-order 32-bit fetch unit repeat a block of instructions without spending any branch or counter instructions inside the block. A setup command is issued from the instruction just before the body. It gives an iteration count and a byte distance to the body's final instruction. The controller records three values. The body begins at the instruction right after the setup instruction. The body ends at the setup address plus the distance. The third value is the number of passes still to run.

On every cycle the controller compares the fetch address with the recorded end address. When the final body instruction is fetched and more than one pass remains, it raises a redirect in that same cycle, with the body's first address as target, and takes one off the count. On the final pass no redirect is raised. The loop turns off and fetch continues past the body. The final body instruction therefore runs on every pass, and the body runs exactly the requested number of times.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset the loop is inactive: a fetch of any address, including the last address of a loop set up before the reset, raises no redirect.
- R2: A setup records body start = setup address + 4 and body end = setup address + offset, where the two lowest offset bits are ignored (treated as zero).
- R3: While the loop is active, a valid fetch of the body end address with more than one pass remaining raises redirect_valid in the same cycle, with redirect_target equal to the body start address.
- R4: Each redirect lowers the remaining count by one, so a setup with count N produces exactly N-1 redirects and the body runs N times.
- R5: A valid fetch of the body end address with one pass remaining raises no redirect and makes the loop inactive; later fetches of that address raise no redirect.
- R6: A setup with count 0 leaves the loop inactive.
- R7: A setup whose offset, with its two lowest bits cleared, is below 4 (an empty body) leaves the loop inactive.
- R8: While fetch_valid is low, no redirect is raised and the remaining count does not change.
- R9: A valid fetch of any address other than the body end raises no redirect and leaves the count unchanged.
- R10: A setup in the same cycle as a matching fetch takes priority: no redirect is raised, and the new loop replaces the old one.
- R11: redirect_target reads zero whenever redirect_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_valid | input | 1 | A loop setup command is issued this cycle |
| setup_pc | input | ADDR_W | Address of the setup instruction |
| setup_count | input | CNT_W | Number of times the body runs |
| setup_end_off | input | OFF_W | Unsigned byte distance from setup_pc to the body's last instruction |
| fetch_valid | input | 1 | fetch_pc holds an address that is being fetched this cycle |
| fetch_pc | input | ADDR_W | Current fetch address |
| redirect_valid | output | 1 | Fetch must jump to redirect_target instead of continuing in sequence |
| redirect_target | output | ADDR_W | Body start address while redirect_valid is high, zero otherwise |

## Verification
The bench targets the final pass of the loop. A design off by one there would jump back one time too many or one time too few, and a long 100-pass run counts the redirects exactly. It also covers a one-instruction body, where the end and start addresses coincide. A flawed comparison there would never loop or never stop. A count of zero and an offset that points at the setup instruction itself must both leave the loop off, where a careless design would wrap the counter or loop forever. It checks that a setup arriving on a matching fetch overrides the old loop, that a stalled fetch does not consume a pass, and that a reset in the middle of a loop disarms it.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

  // Per-cycle decision taken by the match stage and applied by the state stage.
  typedef enum logic [1:0] {
    HL_IDLE = 2'd0,  // nothing happens
    HL_BACK = 2'd1,  // end fetched, passes remain: jump back and count down
    HL_EXIT = 2'd2,  // end fetched on the final pass: fall through, disarm
    HL_LOAD = 2'd3   // setup command: load a new loop
  } hl_act_e;

endpackage

// File: rtl/hwloop_setup_dec.sv
module hwloop_setup_dec #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] setup_pc,
  input  logic [CNT_W-1:0]  setup_count,
  input  logic [OFF_W-1:0]  setup_end_off,
  output logic [ADDR_W-1:0] body_start,
  output logic [ADDR_W-1:0] body_end,
  output logic              body_arm
);

  localparam int          INSN_BYTES = 4;
  localparam int          PAD_W      = ADDR_W - OFF_W;

  // Word-aligned offset: the two lowest bits never carry information.
  function automatic logic [ADDR_W-1:0] aligned_off(input logic [OFF_W-1:0] off);
    logic [OFF_W-1:0] masked;
    masked = {off[OFF_W-1:2], 2'b00};
    return {{PAD_W{1'b0}}, masked};
  endfunction

  function automatic logic [ADDR_W-1:0] start_of(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(INSN_BYTES);
  endfunction

  function automatic logic [ADDR_W-1:0] end_of(input logic [ADDR_W-1:0] pc,
                                               input logic [OFF_W-1:0]  off);
    return pc + aligned_off(off);
  endfunction

  // A body holds at least one instruction when the aligned offset is 4 or more.
  function automatic logic body_nonempty(input logic [OFF_W-1:0] off);
    return |off[OFF_W-1:2];
  endfunction

  always_comb begin
    body_start = start_of(setup_pc);
    body_end   = end_of(setup_pc, setup_end_off);
    body_arm   = (setup_count != '0) && body_nonempty(setup_end_off);
  end

endmodule

// File: rtl/hwloop_match.sv
module hwloop_match
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              loop_on,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [CNT_W-1:0]  passes_left,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              setup_valid,
  output logic              end_hit,
  output hl_act_e           action
);

  // More than one pass remains when any bit above bit 0 is set.
  function automatic logic more_passes(input logic [CNT_W-1:0] c);
    return |c[CNT_W-1:1];
  endfunction

  always_comb begin
    end_hit = loop_on && fetch_valid && (fetch_pc == end_addr);
    if (setup_valid) begin
      action = HL_LOAD;
    end else if (end_hit) begin
      action = more_passes(passes_left) ? HL_BACK : HL_EXIT;
    end else begin
      action = HL_IDLE;
    end
  end

endmodule

// File: rtl/hwloop_state.sv
module hwloop_state
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hl_act_e           action,
  input  logic [ADDR_W-1:0] ld_start,
  input  logic [ADDR_W-1:0] ld_end,
  input  logic [CNT_W-1:0]  ld_count,
  input  logic              ld_arm,
  output logic [ADDR_W-1:0] start_q,
  output logic [ADDR_W-1:0] end_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              active_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= '0;
      end_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      unique case (action)
        HL_LOAD: begin
          start_q  <= ld_start;
          end_q    <= ld_end;
          cnt_q    <= ld_arm ? ld_count : '0;
          active_q <= ld_arm;
        end
        HL_BACK: begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        HL_EXIT: begin
          cnt_q    <= '0;
          active_q <= 1'b0;
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_valid,
  input  logic [ADDR_W-1:0] setup_pc,
  input  logic [CNT_W-1:0]  setup_count,
  input  logic [OFF_W-1:0]  setup_end_off,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_target
);

  logic [ADDR_W-1:0] dec_start;
  logic [ADDR_W-1:0] dec_end;
  logic              dec_arm;
  logic [ADDR_W-1:0] start_q;
  logic [ADDR_W-1:0] end_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              active_q;
  logic              end_hit;
  hl_act_e           action;

  // Named events, visible to the bound checker.
  logic              take_back;
  logic              loop_exit;
  logic              setup_load;

  hwloop_setup_dec #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFF_W(OFF_W)
  ) u_dec (
    .setup_pc      (setup_pc),
    .setup_count   (setup_count),
    .setup_end_off (setup_end_off),
    .body_start    (dec_start),
    .body_end      (dec_end),
    .body_arm      (dec_arm)
  );

  hwloop_match #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_match (
    .loop_on     (active_q),
    .end_addr    (end_q),
    .passes_left (cnt_q),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .setup_valid (setup_valid),
    .end_hit     (end_hit),
    .action      (action)
  );

  hwloop_state #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .action   (action),
    .ld_start (dec_start),
    .ld_end   (dec_end),
    .ld_count (setup_count),
    .ld_arm   (dec_arm),
    .start_q  (start_q),
    .end_q    (end_q),
    .cnt_q    (cnt_q),
    .active_q (active_q)
  );

  assign take_back  = (action == HL_BACK);
  assign loop_exit  = (action == HL_EXIT);
  assign setup_load = (action == HL_LOAD);

  assign redirect_valid  = take_back;
  assign redirect_target = take_back ? start_q : '0;

endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              setup_valid,
  input logic [CNT_W-1:0]  setup_count,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              redirect_valid,
  input logic [ADDR_W-1:0] redirect_target,
  input logic              active_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [ADDR_W-1:0] end_q,
  input logic              take_back,
  input logic              loop_exit
);

  p_stall_no_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> fetch_valid);

  p_setup_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
    setup_valid |-> !redirect_valid);

  p_backward_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (fetch_pc == end_q) && (redirect_target <= fetch_pc));

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_back |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

  p_live_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> cnt_q != '0);

  p_last_pass_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_exit |=> !active_q);

  p_zero_count_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_valid && setup_count == '0) |=> !active_q);

  p_idle_no_redirect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !redirect_valid);

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .setup_valid     (setup_valid),
  .setup_count     (setup_count),
  .fetch_valid     (fetch_valid),
  .fetch_pc        (fetch_pc),
  .redirect_valid  (redirect_valid),
  .redirect_target (redirect_target),
  .active_q        (active_q),
  .cnt_q           (cnt_q),
  .end_q           (end_q),
  .take_back       (take_back),
  .loop_exit       (loop_exit)
);

// File: tb/hwloop_ctrl_test.sv
`timescale 1ns/1ps
module hwloop_ctrl_test;

  localparam int ADDR_W = 32;
  localparam int CNT_W  = 12;
  localparam int OFF_W  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              setup_valid = 1'b0;
  logic [ADDR_W-1:0] setup_pc = '0;
  logic [CNT_W-1:0]  setup_count = '0;
  logic [OFF_W-1:0]  setup_end_off = '0;
  logic              fetch_valid = 1'b0;
  logic [ADDR_W-1:0] fetch_pc = '0;
  logic              redirect_valid;
  logic [ADDR_W-1:0] redirect_target;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hwloop_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFF_W(OFF_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .setup_valid(setup_valid), .setup_pc(setup_pc),
    .setup_count(setup_count), .setup_end_off(setup_end_off),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .redirect_valid(redirect_valid), .redirect_target(redirect_target)
  );

  typedef struct packed {
    logic        sv;
    logic [31:0] spc;
    logic [11:0] cnt;
    logic [11:0] off;
    logic        fv;
    logic [31:0] fpc;
    logic        rv;
    logic [31:0] tgt;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 28;
  localparam vec_t TBL [NVEC] = '{
    // loop A: start 0x104, end 0x110, three passes (R2, R3, R4, R5, R8, R9)
    '{1'b1, 32'h100, 12'd3, 12'h010, 1'b1, 32'h100, 1'b0, 32'h0,   4'd2},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h104, 1'b0, 32'h0,   4'd9},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h110, 1'b1, 32'h104, 4'd3},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h108, 1'b0, 32'h0,   4'd9},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h110, 1'b1, 32'h104, 4'd4},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b0, 32'h110, 1'b0, 32'h0,   4'd8},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h110, 1'b0, 32'h0,   4'd5},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h110, 1'b0, 32'h0,   4'd5},
    // loop B: offset 0x00B masked to 0x008 (R2)
    '{1'b1, 32'h200, 12'd2, 12'h00B, 1'b1, 32'h200, 1'b0, 32'h0,   4'd2},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h208, 1'b1, 32'h204, 4'd2},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h208, 1'b0, 32'h0,   4'd5},
    // count zero (R6)
    '{1'b1, 32'h300, 12'd0, 12'h008, 1'b1, 32'h300, 1'b0, 32'h0,   4'd6},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h308, 1'b0, 32'h0,   4'd6},
    // empty body, offset 3 masks to 0 (R7)
    '{1'b1, 32'h400, 12'd5, 12'h003, 1'b1, 32'h400, 1'b0, 32'h0,   4'd7},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h400, 1'b0, 32'h0,   4'd7},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h404, 1'b0, 32'h0,   4'd7},
    // one-instruction body at 0x504, four passes (R3, R4)
    '{1'b1, 32'h500, 12'd4, 12'h004, 1'b1, 32'h500, 1'b0, 32'h0,   4'd3},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h504, 1'b1, 32'h504, 4'd3},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h504, 1'b1, 32'h504, 4'd4},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h504, 1'b1, 32'h504, 4'd4},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h504, 1'b0, 32'h0,   4'd4},
    // loop C replaced by loop D on a matching fetch (R10, R11)
    '{1'b1, 32'h600, 12'd9, 12'h020, 1'b1, 32'h600, 1'b0, 32'h0,   4'd2},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h620, 1'b1, 32'h604, 4'd3},
    '{1'b1, 32'h700, 12'd2, 12'h008, 1'b1, 32'h620, 1'b0, 32'h0,   4'd10},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h620, 1'b0, 32'h0,   4'd10},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h708, 1'b1, 32'h704, 4'd10},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b1, 32'h708, 1'b0, 32'h0,   4'd11},
    '{1'b0, 32'h0,   12'd0, 12'h000, 1'b0, 32'h708, 1'b0, 32'h0,   4'd8}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic sv, input logic [31:0] spc, input logic [11:0] cnt,
                       input logic [11:0] off, input logic fv, input logic [31:0] fpc);
    @(negedge clk);
    setup_valid   = sv;
    setup_pc      = spc;
    setup_count   = cnt;
    setup_end_off = off;
    fetch_valid   = fv;
    fetch_pc      = fpc;
    #1;
  endtask

  initial begin
    int redirects;
    // R1: reset state, fetch of an arbitrary address gives no redirect
    repeat (3) @(posedge clk);
    drive(1'b0, 32'h0, 12'd0, 12'd0, 1'b1, 32'h0);
    chk("R1 reset redirect", {31'b0, redirect_valid}, 32'h0);
    chk("R11 reset target", redirect_target, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(TBL[i].sv, TBL[i].spc, TBL[i].cnt, TBL[i].off, TBL[i].fv, TBL[i].fpc);
      chk($sformatf("R%0d vec%0d valid", TBL[i].req, i), {31'b0, redirect_valid},
          {31'b0, TBL[i].rv});
      chk($sformatf("R%0d vec%0d target", TBL[i].req, i), redirect_target, TBL[i].tgt);
    end

    // R4: long loop of 100 passes, three-instruction body 0x1004..0x100C
    drive(1'b1, 32'h1000, 12'd100, 12'h00C, 1'b1, 32'h1000);
    redirects = 0;
    for (int pass = 0; pass < 100; pass++) begin
      drive(1'b0, 32'h0, 12'd0, 12'd0, 1'b1, 32'h1004);
      drive(1'b0, 32'h0, 12'd0, 12'd0, 1'b1, 32'h1008);
      drive(1'b0, 32'h0, 12'd0, 12'd0, 1'b1, 32'h100C);
      if (redirect_valid) redirects++;
      if (pass == 99) chk("R5 final pass falls through", {31'b0, redirect_valid}, 32'h0);
    end
    chk("R4 redirect count for 100 passes", redirects, 32'd99);

    // R1: reset in the middle of an active loop disarms it
    drive(1'b1, 32'h2000, 12'd5, 12'h008, 1'b1, 32'h2000);
    drive(1'b0, 32'h0, 12'd0, 12'd0, 1'b1, 32'h2008);
    chk("R3 loop before reset", redirect_target, 32'h2004);
    drive(1'b0, 32'h0, 12'd0, 12'd0, 1'b0, 32'h0);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 32'h0, 12'd0, 12'd0, 1'b1, 32'h2008);
    chk("R1 no redirect after reset", {31'b0, redirect_valid}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule